// File: doc/BRIEF.md
# Dual-Format Host Register Port

This block sits between a parallel processor bus and a bank of sixteen byte-wide registers. It turns the host's asynchronous chip-enable, address and strobe signals into clean, single-cycle register read and write pulses in the local clock domain. The registers themselves and any serial engine behind them live outside the block: they see only an address, a write pulse with its data byte, a read pulse, and a combinational read-data return.

Two bus shapes are supported. The shape is picked by a strap pin that is sampled while reset is held. In the multiplexed shape, address and data share one byte-wide bus. An address-latch pin marks the address phase, and the separate read and write strobes are active low. In the non-multiplexed shape, the address has its own four pins. The shared strap-select pin then chooses between two strobe conventions: separate active-low read and write strobes, or an active-high data strobe paired with a read/write direction line. The bidirectional data bus is split into an input, an output and an output enable.

Top module: `hostbus_regport`

## Requirements
- R1: While `rst` is high, `strap_mux_n` is sampled. A 0 sets `mode_muxed`=1 and a 1 sets `mode_muxed`=0. Changes to the strap after reset have no effect.
- R2: `irq_pin_en` is 1 only in non-multiplexed mode. In multiplexed mode the pin stays an input.
- R3: While `cs_n` is high, no strobe activity produces `reg_wr`, `reg_rd` or `bus_oe`.
- R4: In multiplexed mode, `bus_in[3:0]` is captured while `ale_mi` is high and held after it falls. That held address is used for the following access. Strobes are `rd_ds` (read) and `wr_rw` (write), both active low. `addr_in` is ignored.
- R5: In non-multiplexed mode with `ale_mi`=1, `rd_ds` and `wr_rw` are active-low read and write strobes, and the address comes from `addr_in`.
- R6: In non-multiplexed mode with `ale_mi`=0, `rd_ds` is an active-high data strobe. With the strobe high, `wr_rw`=1 means read and `wr_rw`=0 means write.
- R7: Each write access gives exactly one `reg_wr` pulse, one cycle long, after the synchronized write qualifier ends. `reg_addr` and `reg_wdata` carry the address and the last data byte seen while the qualifier was active.
- R8: Each read access gives exactly one `reg_rd` pulse with `reg_addr` set. After that, `bus_oe` is high with `bus_out` equal to `rd_data` for that address, and `reg_addr` holds steady. `bus_oe` returns to 0 after the access ends.
- R9: If a write qualifier ends in the same cycle that a read qualifier begins, the write pulse goes first and the read pulse follows one cycle later. `reg_wr` and `reg_rd` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset; strap sampled while high |
| strap_mux_n | input | 1 | Bus-shape strap, low selects multiplexed |
| cs_n | input | 1 | Chip enable, active low |
| ale_mi | input | 1 | Address latch (multiplexed) or strobe-convention select (non-multiplexed) |
| rd_ds | input | 1 | Read strobe (active low) or data strobe (active high) |
| wr_rw | input | 1 | Write strobe (active low) or read/write direction |
| addr_in | input | ADDR_W | Dedicated address pins (non-multiplexed) |
| bus_in | input | DATA_W | Data bus, host to block |
| bus_out | output | DATA_W | Data bus, block to host |
| bus_oe | output | 1 | Drive enable for `bus_out` |
| rd_data | input | DATA_W | Register contents at `reg_addr` |
| reg_wr | output | 1 | Register write pulse |
| reg_rd | output | 1 | Register read pulse |
| reg_addr | output | ADDR_W | Register address |
| reg_wdata | output | DATA_W | Register write data |
| mode_muxed | output | 1 | Latched bus shape, 1 = multiplexed |
| irq_pin_en | output | 1 | Shared pin may act as interrupt output |

## Verification
The hardest case to reach is the write-to-read hand-over in R9. It needs the direction line to flip while the data strobe stays high, so that one qualifier ends on the same synchronized cycle that the other begins. A directed sequence holds the data strobe with the direction low for several cycles and then raises the direction without releasing the strobe. It then checks for both pulses, the correct order, the read data, and no overlap. Random accesses then mix all three conventions, with the strap re-sampled between the two bus shapes.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  typedef enum logic {BUS_SPLIT = 1'b0, BUS_MUXED = 1'b1} bus_fmt_e;

  typedef struct packed {
    logic rd;
    logic wr;
  } strobe_t;
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
  parameter int          W       = 16,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hbi_mode_strap.sv
module hbi_mode_strap
  import hbi_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     strap_n,
  output bus_fmt_e fmt
);
  // sampled continuously while reset holds, frozen afterwards
  always_ff @(posedge clk) begin
    if (rst) fmt <= strap_n ? BUS_SPLIT : BUS_MUXED;
  end
endmodule

// File: rtl/hbi_front.sv
module hbi_front
  import hbi_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_fmt_e          fmt,
  input  logic              cs_n,
  input  logic              ale_mi,
  input  logic              rd_ds,
  input  logic              wr_rw,
  input  logic [ADDR_W-1:0] addr_pins,
  input  logic [DATA_W-1:0] data_pins,
  output strobe_t           stb,
  output logic [ADDR_W-1:0] addr_cur
);
  logic [ADDR_W-1:0] addr_lat;
  logic              rd_raw, wr_raw;

  always_ff @(posedge clk) begin
    if (rst) addr_lat <= '0;
    else if (fmt == BUS_MUXED && ale_mi) addr_lat <= data_pins[ADDR_W-1:0];
  end

  always_comb begin
    if (fmt == BUS_MUXED || ale_mi) begin
      rd_raw = ~rd_ds;
      wr_raw = ~wr_rw;
    end else begin
      rd_raw = rd_ds & wr_rw;
      wr_raw = rd_ds & ~wr_rw;
    end
    stb.rd   = rd_raw & ~cs_n;
    stb.wr   = wr_raw & ~rd_raw & ~cs_n;
    addr_cur = (fmt == BUS_MUXED) ? addr_lat : addr_pins;
  end
endmodule

// File: rtl/hbi_access_ctl.sv
module hbi_access_ctl
  import hbi_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] addr_cur,
  input  logic [DATA_W-1:0] data_cur,
  input  logic [DATA_W-1:0] rd_data,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe
);
  logic              wr_q, rd_seen, wr_done, rd_start;
  logic [ADDR_W-1:0] addr_hold;
  logic [DATA_W-1:0] data_hold;

  assign wr_done  = wr_q & ~stb.wr;
  assign rd_start = stb.rd & ~rd_seen & ~wr_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q      <= 1'b0;
      rd_seen   <= 1'b0;
      addr_hold <= '0;
      data_hold <= '0;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      bus_out   <= '0;
      bus_oe    <= 1'b0;
    end else begin
      wr_q <= stb.wr;
      if (stb.wr) begin
        addr_hold <= addr_cur;
        data_hold <= data_cur;
      end
      reg_wr  <= wr_done;
      reg_rd  <= rd_start;
      rd_seen <= stb.rd & (rd_seen | ~wr_done);
      if (wr_done) begin
        reg_addr  <= addr_hold;
        reg_wdata <= data_hold;
      end else if (rd_start) begin
        reg_addr <= addr_cur;
      end
      bus_oe <= stb.rd & rd_seen;
      if (stb.rd & rd_seen) bus_out <= rd_data;
    end
  end
endmodule

// File: rtl/hostbus_regport.sv
module hostbus_regport
  import hbi_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_mux_n,
  input  logic              cs_n,
  input  logic              ale_mi,
  input  logic              rd_ds,
  input  logic              wr_rw,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  input  logic [DATA_W-1:0] rd_data,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              mode_muxed,
  output logic              irq_pin_en
);
  localparam int SW = 4 + ADDR_W + DATA_W;
  localparam logic [SW-1:0] IDLE = {1'b1, {(SW-1){1'b0}}};

  bus_fmt_e          fmt;
  strobe_t           stb;
  logic [SW-1:0]     pins_s;
  logic [ADDR_W-1:0] addr_cur;
  logic              cs_n_s, ale_s, rd_s, wr_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;

  hbi_mode_strap u_strap (
    .clk(clk), .rst(rst), .strap_n(strap_mux_n), .fmt(fmt)
  );

  hbi_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(IDLE)) u_sync (
    .clk(clk), .rst(rst),
    .d({cs_n, ale_mi, rd_ds, wr_rw, addr_in, bus_in}),
    .q(pins_s)
  );

  assign {cs_n_s, ale_s, rd_s, wr_s, addr_s, data_s} = pins_s;

  hbi_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_front (
    .clk(clk), .rst(rst), .fmt(fmt),
    .cs_n(cs_n_s), .ale_mi(ale_s), .rd_ds(rd_s), .wr_rw(wr_s),
    .addr_pins(addr_s), .data_pins(data_s),
    .stb(stb), .addr_cur(addr_cur)
  );

  hbi_access_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst(rst), .stb(stb),
    .addr_cur(addr_cur), .data_cur(data_s), .rd_data(rd_data),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .bus_out(bus_out), .bus_oe(bus_oe)
  );

  assign mode_muxed = (fmt == BUS_MUXED);
  assign irq_pin_en = (fmt == BUS_SPLIT);
endmodule

// File: rtl/hbi_checker.sv
module hbi_checker #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              bus_oe,
  input logic              mode_muxed
);
  p_wr_single_r7: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> !reg_wr);

  p_rd_wr_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_rd));

  p_oe_after_rd_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_oe) |-> $past(reg_rd));

  p_addr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> $stable(reg_addr));

  p_mode_fixed_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(mode_muxed));
endmodule

bind hostbus_regport hbi_checker #(.ADDR_W(ADDR_W)) u_hbi_checker (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .bus_oe(bus_oe), .mode_muxed(mode_muxed)
);

// File: tb/tb_hostbus_regport.sv
`timescale 1ns/1ps
module tb_hostbus_regport;
  localparam int AW = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strap_mux_n = 1'b0;
  logic cs_n = 1'b1, ale_mi = 1'b0, rd_ds = 1'b1, wr_rw = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] bus_in = '0;
  logic [DW-1:0] bus_out, rd_data, reg_wdata;
  logic [AW-1:0] reg_addr;
  logic bus_oe, reg_wr, reg_rd, mode_muxed, irq_pin_en;

  int nchk = 0, nerr = 0;
  int wr_cnt = 0, rd_cnt = 0, both_cnt = 0, oe_cnt = 0;
  logic [AW-1:0] wr_addr_seen, rd_addr_seen;
  logic [DW-1:0] wr_data_seen;
  bit done = 0;

  always #2 clk = ~clk;

  hostbus_regport dut (
    .clk(clk), .rst(rst), .strap_mux_n(strap_mux_n), .cs_n(cs_n),
    .ale_mi(ale_mi), .rd_ds(rd_ds), .wr_rw(wr_rw), .addr_in(addr_in),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .rd_data(rd_data),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mode_muxed(mode_muxed), .irq_pin_en(irq_pin_en)
  );

  function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
    return {~a, a};
  endfunction

  // register bank model: contents are a fixed function of the address
  assign rd_data = exp_rd(reg_addr);

  always @(negedge clk) begin
    if (!rst) begin
      if (reg_wr) begin
        wr_cnt++; wr_addr_seen = reg_addr; wr_data_seen = reg_wdata;
      end
      if (reg_rd) begin
        rd_cnt++; rd_addr_seen = reg_addr;
      end
      if (reg_wr && reg_rd) both_cnt++;
      if (bus_oe) oe_cnt++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  // conv: 0 multiplexed, 1 split strobes, 2 data strobe + direction
  task automatic set_idle(input int conv);
    cs_n = 1'b1;
    if (conv == 2) begin ale_mi = 1'b0; rd_ds = 1'b0; wr_rw = 1'b1; end
    else begin ale_mi = (conv == 1); rd_ds = 1'b1; wr_rw = 1'b1; end
  endtask

  task automatic do_reset(input bit strap);
    rst = 1'b1; strap_mux_n = strap; set_idle(strap ? 1 : 0);
    tick(4);
    rst = 1'b0;
    tick(1);
    check(!reg_wr && !reg_rd && !bus_oe, "R3 reset state", {reg_wr, reg_rd, bus_oe}, 0);
    strap_mux_n = ~strap;
    tick(4);
    check(mode_muxed == !strap, "R1", mode_muxed, !strap);
    check(irq_pin_en == strap, "R2", irq_pin_en, strap);
  endtask

  task automatic do_access(input int conv, input bit is_wr,
                           input logic [AW-1:0] a, input logic [DW-1:0] d);
    int w0, r0;
    string rq;
    rq = (conv == 0) ? "R4" : (conv == 1) ? "R5" : "R6";
    w0 = wr_cnt; r0 = rd_cnt;
    set_idle(conv);
    tick(1);
    if (conv == 0) begin
      addr_in = AW'($urandom);
      bus_in = {4'($urandom), a};
      ale_mi = 1'b1;
      tick(3);
      ale_mi = 1'b0;
      bus_in = is_wr ? d : DW'($urandom);
      tick(2);
    end else begin
      addr_in = a;
      bus_in = is_wr ? d : DW'($urandom);
    end
    cs_n = 1'b0;
    if (is_wr) begin
      if (conv == 2) begin rd_ds = 1'b1; wr_rw = 1'b0; end else wr_rw = 1'b0;
    end else begin
      if (conv == 2) begin rd_ds = 1'b1; wr_rw = 1'b1; end else rd_ds = 1'b0;
    end
    tick(8);
    if (!is_wr)
      check(bus_oe === 1'b1 && bus_out === exp_rd(a), {rq, " R8 read data"}, {bus_oe, bus_out}, {1'b1, exp_rd(a)});
    set_idle(conv);
    tick(8);
    if (is_wr) begin
      check(wr_cnt == w0 + 1 && rd_cnt == r0, "R7 one write pulse", wr_cnt - w0, 1);
      check(wr_addr_seen == a, {rq, " write address"}, wr_addr_seen, a);
      check(wr_data_seen == d, "R7 write data", wr_data_seen, d);
    end else begin
      check(rd_cnt == r0 + 1 && wr_cnt == w0, "R8 one read pulse", rd_cnt - r0, 1);
      check(rd_addr_seen == a, {rq, " read address"}, rd_addr_seen, a);
      check(bus_oe == 1'b0, "R8 drive released", bus_oe, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    int unsigned seed_init;
    int w0, r0, o0;
    seed_init = $urandom(32'd20240611);

    // multiplexed shape
    do_reset(1'b0);
    do_access(0, 1'b1, 4'hA, 8'h5C);
    do_access(0, 1'b0, 4'h3, 8'h00);
    do_access(0, 1'b0, 4'hF, 8'h00);
    for (int i = 0; i < 30; i++)
      do_access(0, 1'($urandom), AW'($urandom), DW'($urandom));

    // non-multiplexed shape
    do_reset(1'b1);
    do_access(1, 1'b1, 4'h0, 8'hFF);
    do_access(1, 1'b0, 4'h9, 8'h00);
    do_access(2, 1'b1, 4'hF, 8'h01);
    do_access(2, 1'b0, 4'h6, 8'h00);

    // R3: strobes while chip enable is high
    w0 = wr_cnt; r0 = rd_cnt; o0 = oe_cnt;
    set_idle(1); addr_in = 4'h2; bus_in = 8'h77;
    rd_ds = 1'b0; tick(8); rd_ds = 1'b1;
    wr_rw = 1'b0; tick(8); wr_rw = 1'b1;
    ale_mi = 1'b0; rd_ds = 1'b1; tick(8); rd_ds = 1'b0;
    set_idle(1); tick(8);
    check(wr_cnt == w0 && rd_cnt == r0, "R3 no pulses", (wr_cnt - w0) + (rd_cnt - r0), 0);
    check(oe_cnt == o0, "R3 no drive", oe_cnt - o0, 0);

    // R9: direction flips under a held data strobe
    w0 = wr_cnt; r0 = rd_cnt;
    set_idle(2); tick(1);
    addr_in = 4'hC; bus_in = 8'hA5; cs_n = 1'b0; rd_ds = 1'b1; wr_rw = 1'b0;
    tick(6);
    wr_rw = 1'b1;
    tick(8);
    check(bus_oe === 1'b1 && bus_out === exp_rd(4'hC), "R9 read after write", bus_out, exp_rd(4'hC));
    set_idle(2); tick(8);
    check(wr_cnt == w0 + 1 && rd_cnt == r0 + 1, "R9 both pulses", {wr_cnt - w0, rd_cnt - r0}, 2'b11);
    check(wr_data_seen == 8'hA5, "R9 write data", wr_data_seen, 8'hA5);
    check(both_cnt == 0, "R9 no overlap", both_cnt, 0);

    for (int i = 0; i < 60; i++)
      do_access(1 + int'($urandom % 2), 1'($urandom), AW'($urandom), DW'($urandom));

    check(both_cnt == 0, "R9 no overlap overall", both_cnt, 0);
    finish_sim();
  end
endmodule